// File: doc/BRIEF.md
# Posted-Store Queue with Read Forwarding

This block sits between a write-through cache and the lower memory. Processor stores are posted into a small queue, so the processor keeps running while the writes drain to memory one at a time, oldest first. A read that misses the cache is checked against every pending store. When no pending store targets the same word, the read goes to memory ahead of all of them. When one or more do, the data of the most recently posted matching store is returned at once and memory is not read.

The store and read inputs use valid/ready handshakes. A transfer takes place on a rising edge where both are high. The sender holds valid and its payload stable until that edge. The read response is a one-cycle `rsp_valid` pulse with no back-pressure. The memory request port is offered cycle by cycle. The memory takes whatever request is shown on an edge where `mem_req_ready` is high, and the request shown may change while it is not taken. A memory read answers with a one-cycle `mem_rsp_valid` pulse after any delay. Addresses are word addresses.

Top module: `store_bypass_buffer`

## Requirements
- R1: After reset, `st_ready` and `rd_ready` are 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: The queue holds up to DEPTH stores (default 4). While all entries are occupied, `st_ready` is 0 until an entry drains.
- R3: Stores reach memory as write requests (`mem_req_we`=1), in the order they were accepted, with their address and data unchanged. One store is removed per accepted request.
- R4: A read whose word address equals that of a pending store gets `rsp_valid` in the cycle after acceptance, carrying the data of the youngest matching store. No memory read is issued for it.
- R5: A read matching no pending store is offered to memory (`mem_req_we`=0, same address) in the cycle after acceptance, ahead of any pending stores. No store drains until its data returns. The response follows one cycle after `mem_rsp_valid` and carries `mem_rsp_data`.
- R6: `rd_ready` is 0 while a memory read is outstanding.
- R7: A store accepted in the same cycle as a drain is handled in that cycle, so a steady one-store-per-cycle stream with memory always ready never stalls.
- R8: A read accepted in the same cycle as a store to the same word is ordered before that store and does not see its data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Queue can accept a store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| rd_valid | input | 1 | Read offered |
| rd_ready | output | 1 | Read can be accepted |
| rd_addr | input | AW | Read word address |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_data | output | DW | Read data |
| mem_req_valid | output | 1 | Request offered to memory |
| mem_req_ready | input | 1 | Memory takes the request this edge |
| mem_req_we | output | 1 | 1 = write (drain), 0 = read |
| mem_req_addr | output | AW | Request word address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DW | Memory read data |

## Verification
A corrupted head or tail pointer shows up at the first drain after the fault, as a write whose address or data differs from the store queued at that position. A wrong occupancy count shows up either as a false stall on `st_ready` or as a forwarding decision that skips a live entry or uses a dead one. Either mismatch appears as a wrong `rsp_data` or an unexpected memory read within one cycle of the next read. A faulty read-tracking state shows up as a drain that slips in under an outstanding read, or as `rd_ready` rising before the response.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE     = 2'd0,
    PORT_RD_ISSUE = 2'd1,
    PORT_RD_WAIT  = 2'd2
  } port_state_e;
endpackage

// File: rtl/wbuf_store_fifo.sv
module wbuf_store_fifo #(
  parameter int DEPTH = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [AW-1:0]              push_addr,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [CW-1:0]              count,
  output logic [DEPTH-1:0][AW-1:0]   ord_addr,
  output logic [DEPTH-1:0][DW-1:0]   ord_data
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head, tail;

  function automatic logic [PW-1:0] slot_of(input logic [PW-1:0] base, input int unsigned k);
    int unsigned s;
    s = int'(base) + k;
    if (s >= int'(DEPTH)) s = s - int'(DEPTH);
    return PW'(s);
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail] <= push_addr;
      data_q[tail] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= slot_of(tail, 1);
      if (pop)  head <= slot_of(head, 1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // entries presented oldest first: index 0 is the head
  for (genvar k = 0; k < DEPTH; k++) begin : g_order
    assign ord_addr[k] = addr_q[slot_of(head, k)];
    assign ord_data[k] = data_q[slot_of(head, k)];
  end

  // R2
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH)));
  // R3
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
  // R7
  fifo_hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (count == $past(count)));
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int DEPTH = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [AW-1:0]              look_addr,
  input  logic [CW-1:0]              count,
  input  logic [DEPTH-1:0][AW-1:0]   ord_addr,
  input  logic [DEPTH-1:0][DW-1:0]   ord_data,
  output logic                       hit,
  output logic [DW-1:0]              hit_data
);
  // scan oldest to youngest; a later match overrides, so the youngest wins
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if ((CW'(k) < count) && (ord_addr[k] == look_addr)) begin
        hit      = 1'b1;
        hit_data = ord_data[k];
      end
    end
  end
endmodule

// File: rtl/wbuf_port_arb.sv
module wbuf_port_arb
  import wbuf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic          rd_hit,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] fwd_data,
  input  logic          drain_pending,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          rd_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          pop
);
  port_state_e   state;
  logic [AW-1:0] miss_addr_q;

  assign rd_ready      = (state == PORT_IDLE);
  assign mem_req_we    = (state == PORT_IDLE);
  assign mem_req_valid = (state == PORT_RD_ISSUE) || ((state == PORT_IDLE) && drain_pending);
  assign mem_req_addr  = (state == PORT_RD_ISSUE) ? miss_addr_q : head_addr;
  assign mem_req_wdata = head_data;
  assign pop           = (state == PORT_IDLE) && drain_pending && mem_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= PORT_IDLE;
      miss_addr_q <= '0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        PORT_IDLE: begin
          if (rd_fire && rd_hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= fwd_data;
          end else if (rd_fire) begin
            miss_addr_q <= rd_addr;
            state       <= PORT_RD_ISSUE;
          end
        end
        PORT_RD_ISSUE: if (mem_req_ready) state <= PORT_RD_WAIT;
        PORT_RD_WAIT: begin
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            rsp_data  <= mem_rsp_data;
            state     <= PORT_IDLE;
          end
        end
        default: state <= PORT_IDLE;
      endcase
    end
  end

  // R4
  fwd_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && rd_hit) |=> (rsp_valid && rsp_data == $past(fwd_data)));
  // R5
  miss_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !rd_hit) |=> (mem_req_valid && !mem_req_we && mem_req_addr == $past(rd_addr)));
  // R6
  miss_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !rd_hit) |=> !rd_ready);
endmodule

// File: rtl/store_bypass_buffer.sv
module store_bypass_buffer #(
  parameter int DEPTH = 4,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]            count;
  logic [DEPTH-1:0][AW-1:0] ord_addr;
  logic [DEPTH-1:0][DW-1:0] ord_data;
  logic push, pop, rd_fire, hit;
  logic [DW-1:0] hit_data;

  assign st_ready = (count < CW'(DEPTH));
  assign push     = st_valid && st_ready;
  assign rd_fire  = rd_valid && rd_ready;

  wbuf_store_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(st_addr), .push_data(st_data),
    .pop(pop), .count(count), .ord_addr(ord_addr), .ord_data(ord_data));

  wbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .look_addr(rd_addr), .count(count), .ord_addr(ord_addr), .ord_data(ord_data),
    .hit(hit), .hit_data(hit_data));

  wbuf_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .rd_hit(hit), .rd_addr(rd_addr),
    .fwd_data(hit_data), .drain_pending(count != '0), .head_addr(ord_addr[0]),
    .head_data(ord_data[0]), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .pop(pop));
endmodule

// File: tb/store_bypass_buffer_test.sv
`timescale 1ns/1ps
module store_bypass_buffer_test;
  logic clk = 0;
  logic rst_n = 0;
  logic st_valid = 0, rd_valid = 0, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [15:0] st_addr = 0, rd_addr = 0;
  logic [31:0] st_data = 0, mem_rsp_data = 0;
  logic st_ready, rd_ready, rsp_valid, mem_req_valid, mem_req_we;
  logic [31:0] rsp_data, mem_req_wdata;
  logic [15:0] mem_req_addr;

  always #4 clk = ~clk;

  store_bypass_buffer uut (.*);

  int checks = 0, errors = 0;
  logic [31:0] bmem [256];
  logic [31:0] model [256];
  logic [15:0] wq_addr [$];
  logic [31:0] wq_data [$];
  logic [31:0] rq_data [$];
  string       rq_tag [$];
  bit          rq_miss [$];
  string cur_tag = "";
  bit hit_next = 0, miss_next = 0, inflight = 0, count_stalls = 0;
  logic [15:0] miss_addr;
  int mem_reads = 0, exp_mem_reads = 0, overtook = 0, stalls = 0;
  int pend_cnt = 0;
  logic [31:0] pend_data;
  int ready_mode = 0;
  logic [15:0] rdy_lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model drive side
  always begin
    @(posedge clk); #1;
    rdy_lfsr = {rdy_lfsr[14:0], rdy_lfsr[15] ^ rdy_lfsr[13] ^ rdy_lfsr[12] ^ rdy_lfsr[10]};
    mem_req_ready = (ready_mode == 1) || (ready_mode == 2 && rdy_lfsr[0]);
    if (pend_cnt == 1) begin
      pend_cnt = 0; mem_rsp_valid = 1; mem_rsp_data = pend_data;
    end else begin
      if (pend_cnt > 1) pend_cnt--;
      mem_rsp_valid = 0;
    end
  end

  // monitor and scoreboard
  always begin
    bit r_fire, r_hit;
    logic [31:0] r_exp;
    @(negedge clk);
    if (rst_n) begin
      if (hit_next) begin
        chk(rsp_valid === 1'b1, "R4", "forward latency", 32'(rsp_valid), 1); hit_next = 0;
      end
      if (miss_next) begin
        chk(mem_req_valid && !mem_req_we && mem_req_addr == miss_addr, "R5", "read issue",
            {15'd0, mem_req_we, mem_req_addr}, {16'd0, miss_addr});
        chk(!rd_ready, "R6", "rd_ready while miss outstanding", 32'(rd_ready), 0);
        miss_next = 0;
      end
      if (rsp_valid) begin
        if (rq_data.size() == 0) chk(0, "R4", "unexpected response", rsp_data, 0);
        else begin
          string t; bit m; logic [31:0] e;
          e = rq_data.pop_front(); t = rq_tag.pop_front(); m = rq_miss.pop_front();
          chk(rsp_data == e, t, "read data", rsp_data, e);
          if (m) inflight = 0;
        end
      end
      r_fire = rd_valid && rd_ready;
      r_hit = 0;
      r_exp = model[rd_addr[7:0]];
      if (r_fire) foreach (wq_addr[i]) if (wq_addr[i] == rd_addr) r_hit = 1;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          if (inflight) chk(0, "R5", "store drained under read", mem_req_addr, 0);
          if (wq_addr.size() == 0) chk(0, "R3", "extra drain", mem_req_addr, 0);
          else begin
            logic [15:0] ea; logic [31:0] ed;
            ea = wq_addr.pop_front(); ed = wq_data.pop_front();
            chk(mem_req_addr == ea, "R3", "drain address", mem_req_addr, ea);
            chk(mem_req_wdata == ed, "R3", "drain data", mem_req_wdata, ed);
            bmem[mem_req_addr[7:0]] = mem_req_wdata;
          end
        end else begin
          mem_reads++;
          if (wq_addr.size() > 0) overtook++;
          pend_cnt = 2; pend_data = bmem[mem_req_addr[7:0]];
        end
      end
      if (r_fire) begin
        rq_data.push_back(r_exp);
        rq_tag.push_back(cur_tag != "" ? cur_tag : (r_hit ? "R4" : "R5"));
        rq_miss.push_back(!r_hit);
        if (r_hit) hit_next = 1;
        else begin
          miss_next = 1; inflight = 1; miss_addr = rd_addr; exp_mem_reads++;
        end
      end
      if (st_valid && st_ready) begin
        wq_addr.push_back(st_addr); wq_data.push_back(st_data);
        model[st_addr[7:0]] = st_data;
      end
      if (count_stalls && st_valid && !st_ready) stalls++;
    end
  end

  task automatic do_store(input logic [15:0] a, input logic [31:0] d);
    @(posedge clk); #1; st_valid = 1; st_addr = a; st_data = d;
    @(negedge clk); while (!st_ready) @(negedge clk);
  endtask
  task automatic st_done();
    @(posedge clk); #1; st_valid = 0;
  endtask
  task automatic do_read(input logic [15:0] a);
    @(posedge clk); #1; rd_valid = 1; rd_addr = a;
    @(negedge clk); while (!rd_ready) @(negedge clk);
  endtask
  task automatic rd_done();
    @(posedge clk); #1; rd_valid = 0;
  endtask
  task automatic wait_idle();
    @(negedge clk);
    while (wq_addr.size() != 0 || inflight || rq_data.size() != 0 || pend_cnt != 0) @(negedge clk);
  endtask

  task automatic run_tests();
    logic [15:0] lf;
    lf = 16'h1234;
    repeat (3) @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(st_ready === 1'b1, "R1", "st_ready", 32'(st_ready), 1);
    chk(rd_ready === 1'b1, "R1", "rd_ready", 32'(rd_ready), 1);
    chk(rsp_valid === 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 0);
    chk(mem_req_valid === 1'b0, "R1", "mem_req_valid", 32'(mem_req_valid), 0);

    ready_mode = 1;
    do_store(16'd10, 32'hA0A0_0010); st_done();
    do_read(16'd10); rd_done();
    do_read(16'd20); rd_done();
    wait_idle();

    // R7 streaming stores with memory always ready
    count_stalls = 1; stalls = 0;
    for (int i = 0; i < 10; i++) do_store(16'(30 + i), 32'hB000_0000 + 32'(i));
    st_done();
    count_stalls = 0;
    chk(stalls == 0, "R7", "stall cycles in stream", stalls, 0);
    wait_idle();

    // R2 fill, R4 youngest forward, R5 overtaking read
    ready_mode = 0;
    do_store(16'd40, 32'hC000_0001);
    do_store(16'd41, 32'hC000_0002);
    do_store(16'd40, 32'hC000_0003);
    do_store(16'd42, 32'hC000_0004);
    st_done();
    @(negedge clk);
    chk(st_ready === 1'b0, "R2", "st_ready when full", 32'(st_ready), 0);
    do_read(16'd40); rd_done();
    @(negedge clk);
    chk(st_ready === 1'b0, "R2", "still full after hit", 32'(st_ready), 0);
    fork
      begin do_read(16'd43); rd_done(); end
      begin do_store(16'd44, 32'hC000_0005); st_done(); end
      begin repeat (6) @(posedge clk); #1; ready_mode = 1; end
    join
    wait_idle();
    chk(overtook > 0, "R5", "read ahead of pending stores", overtook, 1);

    // R8 same-cycle store and read to one word
    cur_tag = "R8";
    fork
      begin do_store(16'd50, 32'hD000_0050); st_done(); end
      begin do_read(16'd50); rd_done(); end
    join
    cur_tag = "";
    wait_idle();

    // mixed traffic on a few words with irregular memory readiness
    ready_mode = 2;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[0]) begin do_store({13'd0, lf[3:1]}, {16'hE000, lf}); st_done(); end
      else begin do_read({13'd0, lf[3:1]}); rd_done(); end
    end
    ready_mode = 1;
    wait_idle();
    chk(mem_reads == exp_mem_reads, "R4", "memory reads issued", mem_reads, exp_mem_reads);
    chk(wq_addr.size() == 0, "R3", "all stores drained", wq_addr.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 32'h1000 + 32'(i) * 7;
      model[i] = bmem[i];
    end
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", "run did not finish", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule